// File: doc/BRIEF.md
# Pipelined Searchable FIFO

This block is a shallow queue that sits between two stages of an instruction pipeline. The producer stage pushes instruction templates into it. Each template is a two-bit kind code, a destination register name and two operand words. The consumer stage reads and pops the oldest template. The producer can also ask, in the same cycle, whether any template still waiting will write a given register. It uses that answer to stall on a data hazard.

Same-cycle operations are ordered as a pipeline would expect. The consumer's peek, pop and clear all take effect before the producer's search and push. A full queue that is popped in a cycle therefore takes a new template in that same cycle. A search never reports a template that is leaving, and never reports one that is only now arriving. A clear, used when a taken branch flushes the queue, wins over a push in the same cycle. The producer sees that push as refused.

Top module: `searchable_pipe_fifo`

## Requirements
- R1: After reset the queue is empty: `enqRdy` is 1, `deqRdy` is 0 and `findHit` is 0.
- R2: Templates leave in the order they were accepted. While `deqRdy` is 1, the `first*` outputs show the oldest template, and a cycle with `deqEn` high removes it.
- R3: Without a clear, `enqRdy` is 1 exactly when the queue holds fewer than DEPTH templates or `deqEn` is high. An `enqEn` while `enqRdy` is 0 changes nothing: the refused template never appears at `first*` and never produces a `findHit`.
- R4: `deqEn` on an empty queue is ignored. The queue stays empty and `deqRdy` stays 0.
- R5: On a full queue, `deqEn` and `enqEn` in the same cycle are both accepted and the queue stays full.
- R6: `findHit` is 1 when a stored template whose kind is add (code 0) or load (code 2) has a destination equal to `findReg`. Branch (code 1) and store (code 3) templates never match, whatever their destination field holds.
- R7: The search does not count the oldest template when it is popped in the same cycle. It also does not count a template pushed in that cycle.
- R8: When `clearEn` is high, `enqRdy` and `findHit` are 0, any push is discarded, and the queue is empty in the next cycle.
- R9: The oldest template's fields at `first*` stay unchanged in every cycle where it is neither popped nor cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enqEn | input | 1 | Push request |
| enqTag | input | 2 | Kind of the template pushed (0 add, 1 branch, 2 load, 3 store) |
| enqDst | input | 5 | Destination register of the template pushed |
| enqOpA | input | 32 | First operand word of the template pushed |
| enqOpB | input | 32 | Second operand word of the template pushed |
| enqRdy | output | 1 | A push is accepted in this cycle |
| deqEn | input | 1 | Pop request |
| deqRdy | output | 1 | Queue holds a template; `first*` are valid |
| firstTag | output | 2 | Kind of the oldest template |
| firstDst | output | 5 | Destination of the oldest template |
| firstOpA | output | 32 | First operand of the oldest template |
| firstOpB | output | 32 | Second operand of the oldest template |
| clearEn | input | 1 | Empty the queue; overrides a push |
| findReg | input | 5 | Register name searched for |
| findHit | output | 1 | A pending writer of `findReg` exists |

## Verification
The bench builds the queue with DEPTH set to 3. A depth that is not a power of two makes the read and write indices wrap by comparison rather than by overflow, and the random phase crosses that wrap many times. Three slots also allow a full queue that mixes writing and non-writing kinds, so that one search sees a hit, a kind-masked miss and an excluded departing head together. Destinations are drawn from a small range so that searches hit often.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  parameter int REG_W  = 5;
  parameter int DATA_W = 32;
  parameter int IDX_W  = 8;

  typedef enum logic [1:0] {
    TAG_ADD    = 2'd0,
    TAG_BRANCH = 2'd1,
    TAG_LOAD   = 2'd2,
    TAG_STORE  = 2'd3
  } tag_e;

  typedef struct packed {
    tag_e              tag;
    logic [REG_W-1:0]  dst;
    logic [DATA_W-1:0] opA;
    logic [DATA_W-1:0] opB;
  } entry_t;

  // strobes from control to storage
  typedef struct packed {
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
  } strobe_t;

  function automatic logic writesReg(entry_t e);
    return (e.tag == TAG_ADD) || (e.tag == TAG_LOAD);
  endfunction
endpackage

// File: rtl/sfq_ctrl.sv
module sfq_ctrl #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enqEn,
  input  logic                  deqEn,
  input  logic                  clearEn,
  output logic                  enqRdy,
  output logic                  deqRdy,
  output sfq_pkg::strobe_t      strobes,
  output logic [DEPTH-1:0]      liveMask,
  output logic [CNT_W-1:0]      fillCount
);
  import sfq_pkg::*;

  logic [IDX_W-1:0] headIdx, tailIdx;
  logic [CNT_W-1:0] count;
  logic isFull, notEmpty, deqFire, enqFire;

  function automatic logic [IDX_W-1:0] bump(logic [IDX_W-1:0] idx);
    return (int'(idx) == DEPTH - 1) ? '0 : idx + 1'b1;
  endfunction

  assign isFull   = (int'(count) == DEPTH);
  assign notEmpty = (count != '0);
  assign deqRdy   = notEmpty;
  // consumer side acts first; clear blocks the producer
  assign deqFire  = deqEn && notEmpty && !clearEn;
  assign enqRdy   = (!isFull || deqEn) && !clearEn;
  assign enqFire  = enqEn && enqRdy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
    end else if (clearEn) begin
      headIdx <= '0;
      tailIdx <= '0;
      count   <= '0;
    end else begin
      if (deqFire) headIdx <= bump(headIdx);
      if (enqFire) tailIdx <= bump(tailIdx);
      case ({enqFire, deqFire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    strobes.wrEn  = enqFire;
    strobes.wrIdx = tailIdx;
    strobes.rdIdx = headIdx;
  end

  // slots visible to the search after the consumer's actions
  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    always_comb begin
      int off;
      off = (i >= int'(headIdx)) ? i - int'(headIdx) : i + DEPTH - int'(headIdx);
      liveMask[i] = !clearEn && (off < int'(count)) && !(deqFire && off == 0);
    end
  end

  assign fillCount = count;
endmodule

// File: rtl/sfq_store.sv
module sfq_store #(
  parameter int DEPTH = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  sfq_pkg::strobe_t              strobes,
  input  sfq_pkg::entry_t               wrData,
  input  logic [sfq_pkg::REG_W-1:0]     findReg,
  input  logic [DEPTH-1:0]              liveMask,
  output sfq_pkg::entry_t               headData,
  output logic                          findHit
);
  import sfq_pkg::*;

  entry_t slots [DEPTH];
  logic [DEPTH-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) slots[strobes.wrIdx[PTR_W-1:0]] <= wrData;
  end

  assign headData = slots[strobes.rdIdx[PTR_W-1:0]];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hitVec[i] = liveMask[i] && writesReg(slots[i]) && (slots[i].dst == findReg);
  end

  assign findHit = |hitVec;
endmodule

// File: rtl/searchable_pipe_fifo.sv
module searchable_pipe_fifo #(
  parameter int DEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enqEn,
  input  logic [1:0]                  enqTag,
  input  logic [sfq_pkg::REG_W-1:0]   enqDst,
  input  logic [sfq_pkg::DATA_W-1:0]  enqOpA,
  input  logic [sfq_pkg::DATA_W-1:0]  enqOpB,
  output logic                        enqRdy,
  input  logic                        deqEn,
  output logic                        deqRdy,
  output logic [1:0]                  firstTag,
  output logic [sfq_pkg::REG_W-1:0]   firstDst,
  output logic [sfq_pkg::DATA_W-1:0]  firstOpA,
  output logic [sfq_pkg::DATA_W-1:0]  firstOpB,
  input  logic                        clearEn,
  input  logic [sfq_pkg::REG_W-1:0]   findReg,
  output logic                        findHit
);
  import sfq_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  strobe_t          strobes;
  logic [DEPTH-1:0] liveMask;
  logic [CNT_W-1:0] fillCount;
  entry_t           wrData, headData;

  always_comb begin
    wrData.tag = tag_e'(enqTag);
    wrData.dst = enqDst;
    wrData.opA = enqOpA;
    wrData.opB = enqOpB;
  end

  sfq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .enqEn(enqEn), .deqEn(deqEn), .clearEn(clearEn),
    .enqRdy(enqRdy), .deqRdy(deqRdy), .strobes(strobes),
    .liveMask(liveMask), .fillCount(fillCount)
  );

  sfq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .strobes(strobes), .wrData(wrData), .findReg(findReg),
    .liveMask(liveMask), .headData(headData), .findHit(findHit)
  );

  assign firstTag = headData.tag;
  assign firstDst = headData.dst;
  assign firstOpA = headData.opA;
  assign firstOpB = headData.opB;
endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        enqEn,
  input logic                        enqRdy,
  input logic                        deqEn,
  input logic                        deqRdy,
  input logic                        clearEn,
  input logic                        findHit,
  input logic [1:0]                  firstTag,
  input logic [sfq_pkg::REG_W-1:0]   firstDst,
  input logic [sfq_pkg::DATA_W-1:0]  firstOpA,
  input logic [sfq_pkg::DATA_W-1:0]  firstOpB,
  input logic [CNT_W-1:0]            fillCount
);
  p_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    int'(fillCount) <= DEPTH);

  p_empty_deq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!deqRdy && !enqEn) |=> !deqRdy);

  p_swap_rdy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (deqRdy && deqEn && !clearEn) |-> enqRdy);

  p_swap_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (int'(fillCount) == DEPTH && deqEn && enqEn && !clearEn) |=> int'(fillCount) == DEPTH);

  p_empty_nohit_r6: assert property (@(posedge clk) disable iff (!rstN)
    !deqRdy |-> !findHit);

  p_clear_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearEn |-> (!enqRdy && !findHit));

  p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    clearEn |=> (!deqRdy && fillCount == '0));

  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (deqRdy && !deqEn && !clearEn) |=>
      (deqRdy && $stable(firstTag) && $stable(firstDst) && $stable(firstOpA) && $stable(firstOpB)));
endmodule

bind searchable_pipe_fifo sfq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .enqEn(enqEn), .enqRdy(enqRdy), .deqEn(deqEn),
  .deqRdy(deqRdy), .clearEn(clearEn), .findHit(findHit), .firstTag(firstTag),
  .firstDst(firstDst), .firstOpA(firstOpA), .firstOpB(firstOpB), .fillCount(fillCount)
);

// File: tb/sim_searchable_pipe_fifo.sv
module sim_searchable_pipe_fifo;
  import sfq_pkg::*;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enqEn = 1'b0, deqEn = 1'b0, clearEn = 1'b0;
  logic [1:0]  enqTag = '0;
  logic [4:0]  enqDst = '0, findReg = '0;
  logic [31:0] enqOpA = '0, enqOpB = '0;
  logic        enqRdy, deqRdy, findHit;
  logic [1:0]  firstTag;
  logic [4:0]  firstDst;
  logic [31:0] firstOpA, firstOpB;

  int checks = 0;
  int failures = 0;
  entry_t model [$];

  always #4 clk = ~clk;

  searchable_pipe_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .enqEn(enqEn), .enqTag(enqTag), .enqDst(enqDst),
    .enqOpA(enqOpA), .enqOpB(enqOpB), .enqRdy(enqRdy), .deqEn(deqEn),
    .deqRdy(deqRdy), .firstTag(firstTag), .firstDst(firstDst),
    .firstOpA(firstOpA), .firstOpB(firstOpB), .clearEn(clearEn),
    .findReg(findReg), .findHit(findHit)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle, compare against the queue model, then advance the model
  task automatic step(bit e, logic [1:0] t, logic [4:0] d, logic [31:0] a, logic [31:0] b,
                      bit dq, bit cl, logic [4:0] fr, string req);
    bit expEnqRdy, expDeqRdy, expHit;
    @(negedge clk);
    enqEn = e; enqTag = t; enqDst = d; enqOpA = a; enqOpB = b;
    deqEn = dq; clearEn = cl; findReg = fr;
    #1;
    expDeqRdy = (model.size() > 0);
    expEnqRdy = ((model.size() < DEPTH) || dq) && !cl;
    expHit = 1'b0;
    if (!cl) begin
      for (int i = ((dq && model.size() > 0) ? 1 : 0); i < model.size(); i++) begin
        if ((model[i].tag == TAG_ADD || model[i].tag == TAG_LOAD) && model[i].dst == fr)
          expHit = 1'b1;
      end
    end
    chk(enqRdy == expEnqRdy, req, "enqRdy", enqRdy, expEnqRdy);
    chk(deqRdy == expDeqRdy, req, "deqRdy", deqRdy, expDeqRdy);
    chk(findHit == expHit, req, "findHit", findHit, expHit);
    if (model.size() > 0) begin
      chk({firstTag, firstDst} == {model[0].tag, model[0].dst}, req, "firstTag/Dst",
          {firstTag, firstDst}, {model[0].tag, model[0].dst});
      chk(firstOpA == model[0].opA, req, "firstOpA", firstOpA, model[0].opA);
      chk(firstOpB == model[0].opB, req, "firstOpB", firstOpB, model[0].opB);
    end
    if (cl) model.delete();
    else begin
      if (dq && model.size() > 0) void'(model.pop_front());
      if (e && expEnqRdy) begin
        entry_t n;
        n.tag = tag_e'(t); n.dst = d; n.opA = a; n.opB = b;
        model.push_back(n);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(enqRdy == 1'b1, "R1", "enqRdy", enqRdy, 1);
    chk(deqRdy == 1'b0, "R1", "deqRdy", deqRdy, 0);
    chk(findHit == 1'b0, "R1", "findHit", findHit, 0);

    // fill: add->r1, load->r2, branch with dst field 5
    step(1, 2'd0, 5'd1, 32'h11, 32'h12, 0, 0, 5'd1, "R2");
    step(1, 2'd2, 5'd2, 32'h21, 32'h22, 0, 0, 5'd1, "R2");
    step(1, 2'd1, 5'd5, 32'h31, 32'h32, 0, 0, 5'd5, "R2");
    step(0, 2'd0, 5'd0, 0, 0, 0, 0, 5'd1, "R6");
    step(0, 2'd0, 5'd0, 0, 0, 0, 0, 5'd2, "R6");
    step(0, 2'd0, 5'd0, 0, 0, 0, 0, 5'd5, "R6");
    // full, push without pop is refused
    step(1, 2'd0, 5'd7, 32'h77, 32'h78, 0, 0, 5'd7, "R3");
    step(0, 2'd0, 5'd0, 0, 0, 0, 0, 5'd7, "R3");
    step(0, 2'd0, 5'd0, 0, 0, 0, 0, 5'd3, "R9");
    // pop the r1 writer while searching for r1
    step(0, 2'd0, 5'd0, 0, 0, 1, 0, 5'd1, "R7");
    // a store to r9 pushed while searching r9 misses
    step(1, 2'd3, 5'd9, 32'h91, 32'h92, 0, 0, 5'd9, "R7");
    // full: pop and push together
    step(1, 2'd0, 5'd4, 32'h41, 32'h42, 1, 0, 5'd2, "R5");
    step(0, 2'd0, 5'd0, 0, 0, 0, 0, 5'd4, "R5");
    step(0, 2'd0, 5'd0, 0, 0, 0, 0, 5'd9, "R6");
    // clear beats push
    step(1, 2'd0, 5'd6, 32'h61, 32'h62, 0, 1, 5'd4, "R8");
    step(0, 2'd0, 5'd0, 0, 0, 0, 0, 5'd6, "R8");
    // pop on empty
    step(0, 2'd0, 5'd0, 0, 0, 1, 0, 5'd0, "R4");
    step(0, 2'd0, 5'd0, 0, 0, 0, 0, 5'd0, "R4");
    // random traffic compared every cycle
    for (int k = 0; k < 600; k++) begin
      step(($urandom % 3) != 0, 2'($urandom % 4), 5'($urandom % 4), $urandom, $urandom,
           ($urandom % 2) == 1, ($urandom % 16) == 0, 5'($urandom % 4), "R2,R9");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule